// File: doc/BRIEF.md
# Subword-Parallel Lane Adder

This block adds or subtracts two 128-bit words as a set of independent, equal-width lanes. A two-bit lane-size control splits the word at run time into sixteen 8-bit, eight 16-bit, four 32-bit or two 64-bit lanes. The carry chain is cut at every lane boundary, so each lane works as its own modular adder. One add/subtract control applies to every lane at once.

Subtraction adds the bitwise inverse of the second operand and injects a carry of one at the bottom of each lane. Each lane also reports whether its signed (two's-complement) result overflowed. Sum and overflow flags are captured in one register stage.

Top module: `simd_lane_adder`

## Requirements
- R1: `lane_sel` picks the lane width: 0 gives 8-bit lanes, 1 gives 16-bit, 2 gives 32-bit and 3 gives 64-bit. Lane k covers bits [k*W +: W] of each operand and of the sum.
- R2: No carry or borrow crosses a lane boundary. Each lane's result depends only on that lane's operand bits and on `sub`.
- R3: With `sub` = 0, every lane of `sum_q` holds (a + b) mod 2^W for that lane.
- R4: With `sub` = 1, every lane of `sum_q` holds (a - b) mod 2^W, formed as a + ~b + 1 inside the lane.
- R5: With `sub` = 0, a lane's overflow flag is 1 exactly when its two operands share a sign and the result's sign differs from it. Equivalently, the true signed sum falls outside the W-bit signed range.
- R6: With `sub` = 1, a lane's overflow flag is 1 exactly when the operand signs differ and the result's sign differs from the sign of a. Equivalently, the true signed difference falls outside the W-bit signed range.
- R7: `ovf_q` has one bit per byte. The flag of lane k sits at bit index k*(W/8) + W/8 - 1, which is the lane's top byte. Every other bit reads 0.
- R8: Results are registered. Inputs sampled at a rising clock edge appear on `sum_q` and `ovf_q` after that edge and hold until the next edge. While `rst_n` is low, both outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_a | input | 128 | First operand word |
| op_b | input | 128 | Second operand word |
| lane_sel | input | 2 | Lane width select (0:8, 1:16, 2:32, 3:64 bits) |
| sub | input | 1 | 1 subtracts op_b from op_a, 0 adds |
| sum_q | output | 128 | Registered lane-wise result |
| ovf_q | output | 16 | Registered per-lane signed overflow, one bit per byte |

## Verification
The main function is driven with every pairing of eight byte patterns, replicated across the word: 00, 01, 55, 7E, 7F, 80, 81 and FF. The FF+01 and 00-01 pairings show whether a carry leaks through a boundary. These pairings give the same result in the narrowest mode and a different one in the wider modes. The 7F/80/81 pairings place operands on both edges of the signed range, which tells the add and subtract overflow rules apart and shows whether a flag lands on the correct byte index. Random word pairs in all four lane sizes and both operations then cover mixed-sign lanes that the replicated patterns cannot produce. Before each new result is registered, the output is checked to still hold the previous one.

// File: rtl/simd_add_pkg.sv
package simd_add_pkg;

  localparam int ATOM_W = 8;

  typedef enum logic [1:0] {
    LANE_8  = 2'd0,
    LANE_16 = 2'd1,
    LANE_32 = 2'd2,
    LANE_64 = 2'd3
  } lane_sel_e;

  // One atom of the adder: b is inverted when subtracting, carry-in supplied by caller.
  function automatic logic [ATOM_W:0] atom_add(input logic [ATOM_W-1:0] a,
                                               input logic [ATOM_W-1:0] b,
                                               input logic sub,
                                               input logic cin);
    logic [ATOM_W-1:0] bx;
    bx = b ^ {ATOM_W{sub}};
    return {1'b0, a} + {1'b0, bx} + {{ATOM_W{1'b0}}, cin};
  endfunction

  // Signed overflow from the sign bits: operands (after inversion) agree, result disagrees.
  function automatic logic sign_ovf(input logic sa, input logic sb,
                                    input logic sr, input logic sub);
    logic sbx;
    sbx = sb ^ sub;
    return (sa == sbx) && (sr != sa);
  endfunction

endpackage

// File: rtl/simd_atom_slice.sv
module simd_atom_slice
  import simd_add_pkg::*;
(
  input  logic [ATOM_W-1:0] a_i,
  input  logic [ATOM_W-1:0] b_i,
  input  logic              sub_i,
  input  logic              cin_i,
  output logic [ATOM_W-1:0] sum_o,
  output logic              cout_o,
  output logic              ovf_o
);
  localparam int MSB = ATOM_W - 1;

  logic [ATOM_W:0] raw;

  assign raw    = atom_add(a_i, b_i, sub_i, cin_i);
  assign sum_o  = raw[MSB:0];
  assign cout_o = raw[ATOM_W];
  assign ovf_o  = sign_ovf(a_i[MSB], b_i[MSB], sum_o[MSB], sub_i);

endmodule

// File: rtl/simd_lane_mask.sv
module simd_lane_mask
  import simd_add_pkg::*;
#(
  parameter int NATOM = 16
) (
  input  lane_sel_e         sel_i,
  output logic [NATOM-1:0]  start_o,
  output logic [NATOM-1:0]  top_o
);
  localparam int IDX_W = (NATOM > 1) ? $clog2(NATOM) : 1;

  logic [IDX_W-1:0] lmask;

  always_comb begin
    lmask = IDX_W'((32'd1 << sel_i) - 32'd1);
  end

  for (genvar i = 0; i < NATOM; i++) begin : g_pos
    assign start_o[i] = ((IDX_W'(i) & lmask) == '0);
    assign top_o[i]   = ((IDX_W'(i + 1) & lmask) == '0);
  end

endmodule

// File: rtl/simd_lane_adder.sv
module simd_lane_adder
  import simd_add_pkg::*;
#(
  parameter int WORD_W = 128
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [WORD_W-1:0]          op_a,
  input  logic [WORD_W-1:0]          op_b,
  input  logic [1:0]                 lane_sel,
  input  logic                       sub,
  output logic [WORD_W-1:0]          sum_q,
  output logic [WORD_W/ATOM_W-1:0]   ovf_q
);
  localparam int NATOM = WORD_W / ATOM_W;

  lane_sel_e         sel_e;
  logic [NATOM-1:0]  start_m;
  logic [NATOM-1:0]  top_m;
  logic [NATOM-1:0]  carry_into;
  logic [NATOM-1:0]  carry_out;
  logic [NATOM-1:0]  atom_ovf;
  logic [NATOM-1:0]  ovf_c;
  logic [WORD_W-1:0] sum_c;
  logic              primed;

  assign sel_e = lane_sel_e'(lane_sel);

  simd_lane_mask #(.NATOM(NATOM)) u_mask (
    .sel_i   (sel_e),
    .start_o (start_m),
    .top_o   (top_m)
  );

  for (genvar i = 0; i < NATOM; i++) begin : g_atom
    if (i == 0) begin : g_first
      assign carry_into[i] = sub;
    end else begin : g_rest
      // Cut point: a lane's first atom takes the operation carry, others chain.
      assign carry_into[i] = start_m[i] ? sub : carry_out[i-1];
    end

    simd_atom_slice u_slice (
      .a_i    (op_a[i*ATOM_W +: ATOM_W]),
      .b_i    (op_b[i*ATOM_W +: ATOM_W]),
      .sub_i  (sub),
      .cin_i  (carry_into[i]),
      .sum_o  (sum_c[i*ATOM_W +: ATOM_W]),
      .cout_o (carry_out[i]),
      .ovf_o  (atom_ovf[i])
    );
  end

  assign ovf_c = atom_ovf & top_m;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_q  <= '0;
      ovf_q  <= '0;
      primed <= 1'b0;
    end else begin
      sum_q  <= sum_c;
      ovf_q  <= ovf_c;
      primed <= 1'b1;
    end
  end

  // Reference values for the assertions, taken straight from the ports.
  logic [ATOM_W:0] low_ref;
  logic [ATOM_W:0] second_ref;
  assign low_ref    = atom_add(op_a[ATOM_W-1:0], op_b[ATOM_W-1:0], sub, sub);
  assign second_ref = atom_add(op_a[2*ATOM_W-1:ATOM_W], op_b[2*ATOM_W-1:ATOM_W], sub, sub);

  AST_RESET_ZERO: assert property (@(posedge clk)
    !rst_n |=> (sum_q == '0 && ovf_q == '0)); // R8

  AST_LOW_ATOM: assert property (@(posedge clk) disable iff (!rst_n)
    primed |-> sum_q[ATOM_W-1:0] == $past(low_ref[ATOM_W-1:0])); // R3 R4

  AST_ATOM_ISOLATED: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && $past(sel_e) == LANE_8) |->
      sum_q[2*ATOM_W-1:ATOM_W] == $past(second_ref[ATOM_W-1:0])); // R2

  AST_OVF_TOP_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    primed |-> (ovf_q & ~$past(top_m)) == '0); // R7

  AST_TOP_LANE_OVF: assert property (@(posedge clk) disable iff (!rst_n)
    primed |-> ovf_q[NATOM-1] == sign_ovf($past(op_a[WORD_W-1]), $past(op_b[WORD_W-1]),
                                          sum_q[WORD_W-1], $past(sub))); // R5 R6

endmodule

// File: tb/sim_simd_lane_adder.sv
module sim_simd_lane_adder;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [127:0] op_a = '0;
  logic [127:0] op_b = '0;
  logic [1:0]   lane_sel = 2'd0;
  logic         sub = 1'b0;
  logic [127:0] sum_q;
  logic [15:0]  ovf_q;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  simd_lane_adder u0 (
    .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b),
    .lane_sel(lane_sel), .sub(sub), .sum_q(sum_q), .ovf_q(ovf_q)
  );

  // Arithmetic model: lane values as integers, overflow from the true signed result.
  task automatic model(input logic [127:0] a, input logic [127:0] b,
                       input logic [1:0] sel, input logic s,
                       output logic [127:0] es, output logic [15:0] eo);
    int w;
    int nl;
    w  = 8 << sel;
    nl = 128 / w;
    es = '0;
    eo = '0;
    for (int l = 0; l < nl; l++) begin
      logic [63:0] m, av, bv, rv;
      logic signed [67:0] sa, sb, t, hi, lo;
      m  = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
      av = 64'(a >> (l * w)) & m;
      bv = 64'(b >> (l * w)) & m;
      rv = (s ? (av - bv) : (av + bv)) & m;
      es = es | (128'(rv) << (l * w));
      sa = $signed({4'b0, av});
      if (av[w-1]) sa = sa - (68'sd1 <<< w);
      sb = $signed({4'b0, bv});
      if (bv[w-1]) sb = sb - (68'sd1 <<< w);
      t  = s ? (sa - sb) : (sa + sb);
      hi = (68'sd1 <<< (w - 1)) - 68'sd1;
      lo = -(68'sd1 <<< (w - 1));
      if (t > hi || t < lo) eo[l * (w / 8) + w / 8 - 1] = 1'b1;
    end
  endtask

  logic [127:0] prev_sum = '0;
  logic [15:0]  prev_ovf = '0;

  task automatic apply(input logic [127:0] a, input logic [127:0] b,
                       input logic [1:0] sel, input logic s);
    logic [127:0] es;
    logic [15:0]  eo;
    string rs, ro;
    rs = s ? "R4" : "R3";
    ro = s ? "R6" : "R5";
    model(a, b, sel, s, es, eo);
    @(negedge clk);
    op_a = a; op_b = b; lane_sel = sel; sub = s;
    #1;
    checks++;
    if (sum_q !== prev_sum || ovf_q !== prev_ovf) begin
      errors++;
      $display("FAIL R8 output changed before edge: got %h/%h exp %h/%h",
               sum_q, ovf_q, prev_sum, prev_ovf);
    end
    @(negedge clk);
    checks++;
    if (sum_q !== es) begin
      errors++;
      $display("FAIL R1 R2 %s sum sel=%0d: got %h exp %h", rs, sel, sum_q, es);
    end
    checks++;
    if (ovf_q !== eo) begin
      errors++;
      $display("FAIL R7 %s ovf sel=%0d a=%h b=%h: got %h exp %h", ro, sel, a, b, ovf_q, eo);
    end
    prev_sum = es;
    prev_ovf = eo;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired: got hang exp completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] pats [8];
    pats[0] = 8'h00; pats[1] = 8'h01; pats[2] = 8'h55; pats[3] = 8'h7e;
    pats[4] = 8'h7f; pats[5] = 8'h80; pats[6] = 8'h81; pats[7] = 8'hff;

    repeat (3) @(negedge clk);
    checks++;
    if (sum_q !== '0 || ovf_q !== '0) begin // R8 reset state
      errors++;
      $display("FAIL R8 reset: got %h/%h exp 0/0", sum_q, ovf_q);
    end
    rst_n = 1'b1;

    for (int sel = 0; sel < 4; sel++) begin
      for (int s = 0; s < 2; s++) begin
        for (int i = 0; i < 8; i++) begin
          for (int j = 0; j < 8; j++) begin
            apply({16{pats[i]}}, {16{pats[j]}}, 2'(sel), 1'(s));
          end
        end
        for (int k = 0; k < 120; k++) begin
          apply({$urandom, $urandom, $urandom, $urandom},
                {$urandom, $urandom, $urandom, $urandom}, 2'(sel), 1'(s));
        end
      end
    end

    // R8: asynchronous reset clears a non-zero result.
    apply({16{8'h7f}}, {16{8'h01}}, 2'd0, 1'b0);
    rst_n = 1'b0;
    #1;
    checks++;
    if (sum_q !== '0 || ovf_q !== '0) begin
      errors++;
      $display("FAIL R8 reset mid-run: got %h/%h exp 0/0", sum_q, ovf_q);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule